// File: doc/BRIEF.md
# Serial Control Register Port

This block is a write-only, three-wire control port for an audio converter. A host drives a shift clock, a data line and a latch strobe. Each bit on the data line is taken on a rising edge of the shift clock, most significant bit first. A falling edge on the latch strobe commits the last sixteen bits taken. Two address bits inside that word pick which of four control registers receives it.

All three serial inputs are brought into the system clock domain through synchronisers, and edges are found there. The shift clock therefore has to run well below the system clock. Each level of the latch strobe must last at least one system clock plus setup time.

After reset every register holds a fixed, non-zero reset image. Commits are thrown away until a settling window of system clocks has passed. The decoded fields go straight out as plain control pins: two attenuation levels with their load bits, mute, de-emphasis select, output disable, zero-detect enable, the input-format bits and the output routing code. Applying these settings to audio is done elsewhere.

Top module: `serctl_regfile`

## Requirements
- R1: After reset, the four register images are 0x00FF (reg 0), 0x02FF (reg 1), 0x0400 (reg 2) and 0x0690 (reg 3), read back through the output fields defined in R6 to R8.
- R2: Data is taken on each rising shift-clock edge, most significant bit first. A commit uses the last 16 bits taken, and any earlier bits are dropped.
- R3: Word bits 10:9 pick the target: 00 selects reg 0, 01 reg 1, 10 reg 2 and 11 reg 3. The other three registers are left as they were.
- R4: Only a falling edge on the latch strobe commits. Shifting bits while the strobe stays high changes no output.
- R5: A commit detected before LOCK_CYCLES (default 1024) system clocks have passed since reset release is discarded. Commits after that point take effect.
- R6: Reg 0 drives the left attenuation level from bits 7:0 and the left load bit from bit 8. Reg 1 drives the same two fields for the right channel.
- R7: Reg 2 drives mute from bit 0, de-emphasis select from bits 2:1, output disable from bit 3 and zero-detect enable from bit 4.
- R8: Reg 3 drives I2S select from bit 0, frame-clock polarity from bit 1, long word length from bit 2, common attenuation from bit 3 and the routing code from bits 7:4.
- R9: Bits 15:11 are reserved. Their values have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdat_i | input | 1 | Serial data (asynchronous) |
| slat_i | input | 1 | Latch strobe, commits on falling edge (asynchronous) |
| att_left | output | 8 | Left attenuation level |
| att_left_load | output | 1 | Left attenuation load bit |
| att_right | output | 8 | Right attenuation level |
| att_right_load | output | 1 | Right attenuation load bit |
| mute | output | 1 | Soft mute |
| deemph_sel | output | 2 | De-emphasis select |
| out_disable | output | 1 | Force output to mid-scale |
| zdet_en | output | 1 | Zero-detect enable |
| fmt_i2s | output | 1 | I2S input format select |
| lr_polarity | output | 1 | Frame-clock polarity |
| word_long | output | 1 | Long input word select |
| att_common | output | 1 | Use the left level for both channels |
| route | output | 4 | Output routing code |

## Verification
Two functions can act in the same cycle: the settling lockout ends, and a latch-strobe fall arrives. The bench counts system clocks from reset release. It times one latch fall so that it is detected a few clocks before the window closes, and another so that it is detected shortly after. The first commit must leave every output at its reset image. The second must update the addressed register, and the bench compares all four registers against its own model.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int WORD_W = 16;
  localparam int NREG   = 4;
  localparam int ADDR_W = $clog2(NREG);
  localparam int ADDR_LO = 9;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // Image each register returns to on reset
  function automatic word_t reset_image(input int idx);
    case (idx)
      0:       return 16'h00FF;
      1:       return 16'h02FF;
      2:       return 16'h0400;
      default: return 16'h0690;
    endcase
  endfunction

  // Bits that a register actually keeps
  function automatic word_t keep_mask(input int idx);
    case (idx)
      0, 1:    return 16'h01FF;
      2:       return 16'h001F;
      default: return 16'h00FF;
    endcase
  endfunction
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] IDLE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] prev;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{IDLE[b]}};
      else        chain <= {chain[STAGES-2:0], din[b]};
    end
    assign level[b] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= IDLE;
    else        prev <= level;
  end

  assign rise = level & ~prev;
  assign fall = ~level & prev;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise[0] |=> !rise[0]);
  // R4
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall[W-1] |=> !fall[W-1]);
endmodule

// File: rtl/serctl_shift.sv
module serctl_shift
  import serctl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  dat,
  output word_t word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    word <= '0;
    else if (take) word <= {word[WORD_W-2:0], dat};
  end

  // R2
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (word[0] == $past(dat)) && (word[WORD_W-1:1] == $past(word[WORD_W-2:0])));
  // R2
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(word));
endmodule

// File: rtl/serctl_lockout.sv
module serctl_lockout #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  output logic open_q
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign open_q = (cnt == LAST);

  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |=> open_q);
endmodule

// File: rtl/serctl_bank.sv
module serctl_bank
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              open_q,
  input  word_t             word,
  output word_t [NREG-1:0]  regs
);
  addr_t           sel;
  logic [NREG-1:0] wr;

  assign sel = word[ADDR_LO +: ADDR_W];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam word_t RST  = reset_image(i);
    localparam word_t KEEP = keep_mask(i);
    assign wr[i] = commit && open_q && (sel == addr_t'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     regs[i] <= RST & KEEP;
      else if (wr[i]) regs[i] <= word & KEEP;
    end
  end

  // R3
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr));
  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !open_q |=> $stable(regs));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(regs));
endmodule

// File: rtl/serctl_regfile.sv
module serctl_regfile
  import serctl_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       sdat_i,
  input  logic       slat_i,
  output logic [7:0] att_left,
  output logic       att_left_load,
  output logic [7:0] att_right,
  output logic       att_right_load,
  output logic       mute,
  output logic [1:0] deemph_sel,
  output logic       out_disable,
  output logic       zdet_en,
  output logic       fmt_i2s,
  output logic       lr_polarity,
  output logic       word_long,
  output logic       att_common,
  output logic [3:0] route
);
  // pin order inside the sync bundle: {latch, data, shift clock}
  logic [2:0] lvl, rise, fall;
  word_t      word;
  logic       open_q;
  word_t [NREG-1:0] regs;

  serctl_sync #(.W(3), .STAGES(SYNC_STAGES), .IDLE(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({slat_i, sdat_i, sclk_i}),
    .level(lvl), .rise(rise), .fall(fall));

  serctl_shift u_shift (
    .clk(clk), .rst_n(rst_n), .take(rise[0]), .dat(lvl[1]), .word(word));

  serctl_lockout #(.CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_n), .open_q(open_q));

  serctl_bank u_bank (
    .clk(clk), .rst_n(rst_n), .commit(fall[2]), .open_q(open_q),
    .word(word), .regs(regs));

  // R6
  assign att_left       = regs[0][7:0];
  assign att_left_load  = regs[0][8];
  assign att_right      = regs[1][7:0];
  assign att_right_load = regs[1][8];
  // R7
  assign mute        = regs[2][0];
  assign deemph_sel  = regs[2][2:1];
  assign out_disable = regs[2][3];
  assign zdet_en     = regs[2][4];
  // R8
  assign fmt_i2s     = regs[3][0];
  assign lr_polarity = regs[3][1];
  assign word_long   = regs[3][2];
  assign att_common  = regs[3][3];
  assign route       = regs[3][7:4];

  // R9
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regs[0][15:9] == '0) && (regs[1][15:9] == '0) && (regs[2][15:5] == '0) && (regs[3][15:8] == '0));
endmodule

// File: tb/serctl_regfile_test.sv
module serctl_regfile_test;
  logic clk = 0, rst_n = 0;
  logic sclk_i = 0, sdat_i = 0, slat_i = 1;
  logic [7:0] att_left, att_right;
  logic att_left_load, att_right_load, mute, out_disable, zdet_en;
  logic fmt_i2s, lr_polarity, word_long, att_common;
  logic [1:0] deemph_sel;
  logic [3:0] route;

  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] model [4];

  localparam int LOCK = 1024;
  localparam int NVEC = 9;
  localparam logic [15:0] VEC [NVEC] = '{
    16'h0012, 16'h0180, 16'h0255, 16'h03AA, 16'h0415,
    16'h040E, 16'h06A5, 16'h065A, 16'hF8FF };
  localparam logic [15:0] KEEP [4] = '{16'h01FF, 16'h01FF, 16'h001F, 16'h00FF};

  always #2.5 clk = ~clk;

  serctl_regfile #(.LOCK_CYCLES(LOCK)) uut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdat_i(sdat_i), .slat_i(slat_i),
    .att_left(att_left), .att_left_load(att_left_load),
    .att_right(att_right), .att_right_load(att_right_load),
    .mute(mute), .deemph_sel(deemph_sel), .out_disable(out_disable),
    .zdet_en(zdet_en), .fmt_i2s(fmt_i2s), .lr_polarity(lr_polarity),
    .word_long(word_long), .att_common(att_common), .route(route));

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    summary();
  end

  function automatic logic [15:0] obs(input int a);
    case (a)
      0: return {7'b0, att_left_load, att_left};
      1: return {7'b0, att_right_load, att_right};
      2: return {11'b0, zdet_en, out_disable, deemph_sel, mute};
      default: return {8'b0, route, att_common, word_long, lr_polarity, fmt_i2s};
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int a = 0; a < 4; a++) check(req, obs(a), model[a]);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdat_i = v[i]; sclk_i = 0; tick(3);
      sclk_i = 1; tick(3);
      sclk_i = 0;
    end
    tick(3);
  endtask

  task automatic latch();
    slat_i = 0; tick(4);
    slat_i = 1; tick(6);
  endtask

  task automatic apply(input logic [15:0] w);
    shift_bits({16'b0, w}, 16);
    latch();
    model[w[10:9]] = w & KEEP[w[10:9]];
  endtask

  initial begin
    model[0] = 16'h00FF; model[1] = 16'h02FF & 16'h01FF;
    model[2] = 16'h0400 & 16'h001F; model[3] = 16'h0690 & 16'h00FF;
    tick(5);
    // R1: reset images visible during reset
    check_all("R1");
    rst_n = 1;
    tick(2);
    check_all("R1");

    // R5: a commit shortly after reset is discarded
    shift_bits(32'h0000_0155, 16);
    latch();
    check_all("R5");

    // R5: latch fall detected a few clocks before the window closes
    shift_bits(32'h0000_0477, 16);
    while (cyc < LOCK - 20) @(negedge clk);
    slat_i = 0; tick(4); slat_i = 1; tick(4);
    check_all("R5");
    // same shifted word, latched just after the window
    while (cyc < LOCK + 10) @(negedge clk);
    latch();
    model[2] = 16'h0477 & 16'h001F;
    check_all("R5");

    // R3 R6 R7 R8 R9: vector table; all four registers compared each time
    for (int k = 0; k < NVEC; k++) begin
      apply(VEC[k]);
      check_all(k == NVEC - 1 ? "R9" : (VEC[k][10:9] == 2'd3 ? "R8" :
               (VEC[k][10:9] == 2'd2 ? "R7" : "R6")));
    end
    check(":R3", obs(1), 16'h01AA);

    // R4: shifting without a latch fall changes nothing
    shift_bits(32'h0000_04FF, 16);
    check_all("R4");
    // R2: 20 bits shifted; only the last 16 count
    shift_bits(32'h000F_0633, 20);
    latch();
    model[3] = 16'h0033;
    check_all("R2");
    check("R8", {12'b0, route}, 16'h0003);

    summary();
  end
endmodule